// File: doc/BRIEF.md
# Supply Shutdown Supervisor

This block decides, once per clock, whether the main switching supply of a power unit must be held off. It takes a remote request in which high means "turn off" and low means "run". Before that request reaches the output, it passes through a filter with two different delays. A rising request must stay high for a short hold before it takes effect. A falling request must stay low for a much longer hold. Any excursion shorter than the hold is discarded.

Fault handling uses a sticky latch. Either of two comparator flags sets it: an over-voltage flag (covering every rail and the extra protect input) or an under-voltage flag. While the latch is set, the supply is forced off. Only the filtered remote request clears it, so a tripped supply restarts only after the remote is cycled off and back on.

Under-voltage is meaningless while the outputs are still ramping. The flag is therefore ignored in two cases:
- while the filtered request is high;
- for a start-up window counted in millisecond ticks after the filtered request falls.

All delays count a one-cycle millisecond tick supplied from outside. The remote, over-voltage and under-voltage inputs are resynchronised inside the block. The remote synchroniser resets to the "off" level, so an input that has not been driven yet reads as a request to stay off.

Top module: `shutdown_supervisor`

## Requirements
- R1: During and after reset, the delayed remote output is 1 and the shutdown output is 1. The remote input is taken as high (off) until it has been seen low for the full release delay.
- R2: A remote level of 1 takes effect only after it has stayed high through ON_MS tick pulses. The delayed remote output rises in the cycle following the ON_MS-th tick and not earlier.
- R3: A remote level of 0 takes effect only after it has stayed low through OFF_MS tick pulses. The delayed remote output falls in the cycle following the OFF_MS-th tick and not earlier.
- R4: If the remote returns to the delayed level before the delay expires, the pending count is discarded. A later excursion then counts again from zero.
- R5: An over-voltage flag of 1 sets the fault latch. The fault latch output is 1 and the shutdown output is 1 while the latch is set.
- R6: Outside the blanking window, an under-voltage flag of 1 sets the fault latch.
- R7: The under-voltage flag has no effect in two cases: while the delayed remote output is 1, and until BLANK_MS tick pulses have followed its fall.
- R8: A delayed remote output of 1 clears the fault latch. The shutdown output is 1 whenever the delayed remote output is 1. The shutdown output is 0 only when both the delayed remote output and the latch are 0.
- R9: When a set condition and the clearing condition are present together, the latch stays set.
- R10: Once set, the latch stays set after the fault flag returns to 0, until the delayed remote output clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond, the timebase of all delays |
| remote_off_req | input | 1 | Remote request: 1 = turn supply off, 0 = run |
| ov_flag | input | 1 | Over-voltage seen on any rail or on the extra protect input |
| uv_flag | input | 1 | Under-voltage seen on any rail |
| shutdown_o | output | 1 | 1 = hold the main supply off |
| rem_delayed_o | output | 1 | Remote request after the asymmetric delay filter |
| fault_latched_o | output | 1 | State of the fault latch |

## Verification
The bound checker watches several properties on every cycle:
- the shutdown output always covers both the delayed remote and the latch;
- the delayed remote changes only on a tick;
- the latch falls only while the delayed remote is high;
- a pending set always leaves the latch set, whatever the clearing input;
- no latch rise without over-voltage occurs while the delayed remote is high.

Other behaviours only the bench scenarios can show:
- the exact tick counts of the two delays;
- the restart of a count after a short glitch;
- the edge of the under-voltage blanking window at its BLANK_MS-th tick;
- the hold of a trip through a remote-off period until the remote is released.

// File: rtl/shutsup_pkg.sv
package shutsup_pkg;

   // resynchronised view of the three asynchronous inputs
   typedef struct packed {
      logic remote;
      logic ov;
      logic uv;
   } sup_in_t;

   localparam int SUP_IN_W = $bits(sup_in_t);

   // reset image: remote reads as "off", faults read as absent
   localparam sup_in_t SUP_IN_RST = '{remote: 1'b1, ov: 1'b0, uv: 1'b0};

   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
            end else begin
               stage_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q_o = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rem_delay_filter.sv
module rem_delay_filter #(
   parameter int ON_TICKS  = 8,
   parameter int OFF_TICKS = 24,
   parameter int CNT_W     = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic raw_i,
   output logic dly_o
);

   logic [CNT_W-1:0] run_cnt_q;
   logic [CNT_W-1:0] limit;
   logic             dly_q;

   // pending fall (dly high) uses the long hold, pending rise the short one
   assign limit = dly_q ? CNT_W'(OFF_TICKS - 1) : CNT_W'(ON_TICKS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly_q     <= 1'b1;
         run_cnt_q <= '0;
      end else if (raw_i == dly_q) begin
         run_cnt_q <= '0;
      end else if (tick_i) begin
         if (run_cnt_q == limit) begin
            dly_q     <= raw_i;
            run_cnt_q <= '0;
         end else begin
            run_cnt_q <= run_cnt_q + 1'b1;
         end
      end
   end

   assign dly_o = dly_q;

endmodule

// File: rtl/uv_blanker.sv
module uv_blanker #(
   parameter int BLANK_TICKS = 250,
   parameter int CNT_W       = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic off_i,
   output logic blank_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(BLANK_TICKS);

   logic [CNT_W-1:0] win_cnt_q;
   logic             win_open;

   assign win_open = (win_cnt_q != LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt_q <= '0;
      end else if (off_i) begin
         win_cnt_q <= '0;
      end else if (tick_i && win_open) begin
         win_cnt_q <= win_cnt_q + 1'b1;
      end
   end

   assign blank_o = off_i | win_open;

endmodule

// File: rtl/fault_latch.sv
module fault_latch #(
   parameter bit RST_SET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   logic q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= RST_SET;
      else if (set_i)  q <= 1'b1;
      else if (clr_i)  q <= 1'b0;
   end

   assign q_o = q;

endmodule

// File: rtl/shutdown_supervisor.sv
module shutdown_supervisor
   import shutsup_pkg::*;
#(
   parameter int ON_MS       = 8,
   parameter int OFF_MS      = 24,
   parameter int BLANK_MS    = 250,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic remote_off_req,
   input  logic ov_flag,
   input  logic uv_flag,
   output logic shutdown_o,
   output logic rem_delayed_o,
   output logic fault_latched_o
);

   localparam int DLY_MAX = (ON_MS > OFF_MS) ? ON_MS : OFF_MS;
   localparam int DLY_W   = cnt_width(DLY_MAX);
   localparam int BLK_W   = cnt_width(BLANK_MS);

   generate
      if (ON_MS < 1 || OFF_MS < 1) begin : g_bad_delay
         $error("remote delays must be at least one tick");
      end
      if (BLANK_MS < 1) begin : g_bad_blank
         $error("blanking window must be at least one tick");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("synchroniser depth out of range");
      end
   endgenerate

   sup_in_t raw_in, sync_in;
   logic    rem_dly, uv_blank, fault_set, latch_q;
   logic    ov_s, uv_s;

   assign raw_in = '{remote: remote_off_req, ov: ov_flag, uv: uv_flag};

   sup_sync #(
      .W       (SUP_IN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SUP_IN_RST)
   ) in_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (sync_in)
   );

   assign ov_s = sync_in.ov;
   assign uv_s = sync_in.uv;

   rem_delay_filter #(
      .ON_TICKS  (ON_MS),
      .OFF_TICKS (OFF_MS),
      .CNT_W     (DLY_W)
   ) rem_flt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (ms_tick),
      .raw_i  (sync_in.remote),
      .dly_o  (rem_dly)
   );

   uv_blanker #(
      .BLANK_TICKS (BLANK_MS),
      .CNT_W       (BLK_W)
   ) uv_blk_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (ms_tick),
      .off_i   (rem_dly),
      .blank_o (uv_blank)
   );

   assign fault_set = ov_s | (uv_s & ~uv_blank);

   fault_latch #(
      .RST_SET (1'b1)
   ) trip_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (fault_set),
      .clr_i (rem_dly),
      .q_o   (latch_q)
   );

   assign shutdown_o      = rem_dly | latch_q;
   assign rem_delayed_o   = rem_dly;
   assign fault_latched_o = latch_q;

endmodule

// File: rtl/shutdown_supervisor_chk.sv
module shutdown_supervisor_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic rem_dly,
   input logic latch,
   input logic shutdown,
   input logic fault_set,
   input logic ov_s
);

   // R8: the delayed remote always forces the supply off
   p_dly_forces_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rem_dly |-> shutdown);

   // R5: a set latch always forces the supply off
   p_latch_forces_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      latch |-> shutdown);

   // R2 / R3: the filtered remote moves only on a tick
   p_dly_moves_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rem_dly) |-> $past(tick));

   // R10: the latch drops only while the delayed remote clears it
   p_latch_falls_by_remote_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(latch) |-> $past(rem_dly));

   // R9: a set request wins over a concurrent clear
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fault_set) |-> latch);

   // R7: without over-voltage, no trip occurs while the delayed remote is high
   p_uv_blank_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(latch) && !$past(ov_s)) |-> !$past(rem_dly));

endmodule

bind shutdown_supervisor shutdown_supervisor_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (ms_tick),
   .rem_dly   (rem_delayed_o),
   .latch     (fault_latched_o),
   .shutdown  (shutdown_o),
   .fault_set (fault_set),
   .ov_s      (ov_s)
);

// File: tb/shutdown_supervisor_tb_top.sv
`timescale 1ns/1ps
module shutdown_supervisor_tb_top;

   localparam int ON_T  = 8;
   localparam int OFF_T = 24;
   localparam int BLK_T = 250;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ms_tick = 1'b0;
   logic remote_off_req = 1'b1;
   logic ov_flag = 1'b0;
   logic uv_flag = 1'b0;
   logic shutdown_o, rem_delayed_o, fault_latched_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   shutdown_supervisor #(
      .ON_MS(ON_T), .OFF_MS(OFF_T), .BLANK_MS(BLK_T), .SYNC_STAGES(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
      .remote_off_req(remote_off_req), .ov_flag(ov_flag), .uv_flag(uv_flag),
      .shutdown_o(shutdown_o), .rem_delayed_o(rem_delayed_o),
      .fault_latched_o(fault_latched_o)
   );

   function automatic logic exp_shutdown(input logic dly, input logic lat);
      return dly | lat;
   endfunction

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) ms_tick = 1'b1;
         @(negedge clk) ms_tick = 1'b0;
      end
   endtask

   task automatic set_remote(input logic v);
      @(negedge clk) remote_off_req = v;
      cycles(3);
   endtask

   task automatic uv_pulse();
      @(negedge clk) uv_flag = 1'b1;
      cycles(4);
      uv_flag = 1'b0;
      cycles(4);
   endtask

   initial begin
      void'($urandom(32'd1234));
      cycles(4);
      // R1: reset image
      check("R1", "dly in reset", rem_delayed_o, 1'b1);
      check("R1", "shutdown in reset", shutdown_o, 1'b1);
      rst_n = 1'b1;
      cycles(3);
      check("R1", "dly after reset", rem_delayed_o, 1'b1);
      check("R8", "latch cleared by dly", fault_latched_o, 1'b0);
      check("R8", "shutdown while dly", shutdown_o, exp_shutdown(1'b1, 1'b0));

      // R3: long release delay
      set_remote(1'b0);
      ticks(OFF_T - 1);
      check("R3", "dly before last tick", rem_delayed_o, 1'b1);
      ticks(1);
      check("R3", "dly after last tick", rem_delayed_o, 1'b0);
      check("R8", "shutdown run", shutdown_o, exp_shutdown(1'b0, 1'b0));

      // R7 / R6: blanking window edge
      ticks(BLK_T - 1);
      uv_pulse();
      check("R7", "uv inside window", fault_latched_o, 1'b0);
      ticks(1);
      uv_pulse();
      check("R6", "uv after window", fault_latched_o, 1'b1);
      check("R5", "shutdown on trip", shutdown_o, 1'b1);
      cycles(10);
      check("R10", "latch held", fault_latched_o, 1'b1);

      // R2 and R8: short hold then clear
      set_remote(1'b1);
      ticks(ON_T - 1);
      check("R2", "dly before last tick", rem_delayed_o, 1'b0);
      check("R10", "still tripped", shutdown_o, 1'b1);
      ticks(1);
      check("R2", "dly after last tick", rem_delayed_o, 1'b1);
      cycles(1);
      check("R8", "latch cleared", fault_latched_o, 1'b0);
      check("R8", "shutdown while dly", shutdown_o, 1'b1);

      // R7: uv ignored while delayed remote high
      @(negedge clk) uv_flag = 1'b1;
      cycles(6);
      check("R7", "uv while off", fault_latched_o, 1'b0);
      uv_flag = 1'b0;
      cycles(3);

      // R4: release count restarts
      set_remote(1'b0);
      ticks(20);
      set_remote(1'b1);
      set_remote(1'b0);
      ticks(OFF_T - 1);
      check("R4", "release restarted", rem_delayed_o, 1'b1);
      ticks(1);
      check("R3", "release done", rem_delayed_o, 1'b0);
      check("R8", "restart run", shutdown_o, 1'b0);

      // R5 / R9: over-voltage, set wins over clear
      @(negedge clk) ov_flag = 1'b1;
      cycles(4);
      check("R5", "ov trips", fault_latched_o, 1'b1);
      check("R5", "ov shutdown", shutdown_o, 1'b1);
      set_remote(1'b1);
      ticks(ON_T);
      cycles(2);
      check("R9", "set beats clear", fault_latched_o, 1'b1);
      ov_flag = 1'b0;
      cycles(4);
      check("R8", "clear after ov gone", fault_latched_o, 1'b0);

      // R4: assert count restarts
      set_remote(1'b0);
      ticks(OFF_T);
      set_remote(1'b1);
      ticks(5);
      set_remote(1'b0);
      set_remote(1'b1);
      ticks(ON_T - 1);
      check("R4", "assert restarted", rem_delayed_o, 1'b0);
      check("R8", "running during count", shutdown_o, 1'b0);
      ticks(1);
      check("R2", "assert done", rem_delayed_o, 1'b1);

      // random short glitches, both directions
      set_remote(1'b0);
      ticks(OFF_T);
      for (int i = 0; i < 12; i++) begin
         int k = $urandom_range(ON_T - 1, 1);
         set_remote(1'b1);
         ticks(k);
         set_remote(1'b0);
         ticks($urandom_range(3, 0));
         check("R4", "high glitch filtered", rem_delayed_o, 1'b0);
         check("R8", "still running", shutdown_o, exp_shutdown(1'b0, 1'b0));
      end
      set_remote(1'b1);
      ticks(ON_T);
      for (int i = 0; i < 12; i++) begin
         int k = $urandom_range(OFF_T - 1, 1);
         set_remote(1'b0);
         ticks(k);
         set_remote(1'b1);
         check("R4", "low glitch filtered", rem_delayed_o, 1'b1);
         check("R8", "still off", shutdown_o, 1'b1);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule